// File: doc/BRIEF.md
# Dual-Modulus Swallow Counter Controller

This block runs on the low-speed side of an external two-modulus prescaler and is clocked by the prescaler output. It holds a programmable main count N and a programmable swallow count A. From these it drives a modulus-control line that makes the prescaler divide by P when the line is high and by P+1 when it is low. Each divide cycle lasts N prescaler output periods. In the first A periods the line is low and in the remaining N−A periods it is high. The division from prescaler input to the reference pulse is therefore A·(P+1) + (N−A)·P = N·P + A.

New settings are written into shadow registers and take effect only at the next divide-cycle boundary, so no cycle ever mixes old and new values. A setting with A greater than N, with N equal to zero, or with A above P−1 is refused: it is flagged for one clock and the previous shadow values stay. When P is 8, 16, 32 or 64, a single binary total-divide word can be loaded instead: its low log2(P) bits become A and its upper bits become N. stepping that word by one then steps the total ratio by one. P may be set anywhere from 3 to 128, and elaboration fails outside that range.

Top module: `swallow_ctrl_top`

## Requirements
- R1: Over each divide cycle, counting P input periods for every output period with modCtl high and P+1 for every period with modCtl low, the sum equals N·P + A for the N and A that the cycle loaded.
- R2: modCtl is low (divide by P+1) for the first A periods of a cycle and high (divide by P) for the remaining N−A periods. With A = 0 it is high for the whole cycle, and with A = N it is low for the whole cycle.
- R3: refPulse is high for exactly the last period of each cycle, so it is high for one clock per N clocks. The next cycle's values are loaded on the clock edge that ends that period. With N = 1, refPulse is high on every clock.
- R4: While rstN is low, the counters and the shadow registers hold DEF_N and DEF_A, cfgErr is 0 and refPulse is 0. After release, the first refPulse is the DEF_N-th period counted from the reset period.
- R5: A write with N = 0, with A > N or with A > P−1 is refused. cfgErr is high for exactly the one clock that follows that write edge, and the shadow values, and so all later cycles, are unchanged. A valid write leaves cfgErr low.
- R6: A write accepted on any clock edge reaches the counters at the first cycle boundary after that edge. A write sampled on the boundary edge itself (while refPulse is high) applies only at the boundary after that.
- R7: With P in {8, 16, 32, 64}, binWrite loads N from binWord bits [N_W+a−1:a] and A from bits [a−1:0], where 2^a = P. The rules of R5 apply to the result. For any other P, binWrite is ignored.
- R8: When cfgWrite and binWrite are high on the same edge, only cfgWrite takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrite | input | 1 | Write strobe for the separate N and A fields |
| cfgN | input | N_W | Main count N |
| cfgA | input | A_W | Swallow count A (A_W = clog2(P)) |
| binWrite | input | 1 | Write strobe for the binary total-divide word |
| binWord | input | N_W+A_W | Binary total-divide word |
| modCtl | output | 1 | Modulus control: 1 selects divide by P, 0 selects divide by P+1 |
| refPulse | output | 1 | One-clock pulse in the last period of each divide cycle |
| cfgErr | output | 1 | One-clock flag marking a refused write |

## Verification
modCtl and refPulse are decoded from the counter registers, so each output is due in the period that starts at the edge that updated the counters. cfgErr is due one edge after the write is sampled. A written setting shows up first in the cycle that starts at the next boundary edge. The bench's behavioural model advances on each rising edge and applies these latencies. The outputs are compared with the model at every falling edge, where they are stable. The total ratio is checked separately each time refPulse appears, by summing P or P+1 per period according to the sampled modCtl.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Strobes from control to datapath, one set per prescaler output period
  typedef struct packed {
    logic reload;   // end of divide cycle: load counters from shadow
    logic stepA;    // swallow count still running: decrement A
    logic takeNew;  // accepted write: update shadow registers
    logic useBin;   // candidate values come from the binary word
  } swcStrobe_t;
endpackage

// File: rtl/swc_datapath.sv
module swc_datapath #(
  parameter int N_W   = 8,
  parameter int A_W   = 3,
  parameter int DEF_N = 10,
  parameter int DEF_A = 0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  swc_pkg::swcStrobe_t  strobe,
  input  logic [N_W-1:0]       cfgN,
  input  logic [A_W-1:0]       cfgA,
  input  logic [N_W+A_W-1:0]   binWord,
  output logic [N_W-1:0]       candN,
  output logic [A_W-1:0]       candA,
  output logic [N_W-1:0]       nCnt,
  output logic [A_W-1:0]       aCnt,
  output logic [N_W-1:0]       shN,
  output logic [A_W-1:0]       shA
);
  localparam logic [N_W-1:0] RST_N = N_W'(DEF_N);
  localparam logic [A_W-1:0] RST_A = A_W'(DEF_A);

  // Candidate values: split binary word (upper -> N, low bits -> A) or fields
  always_comb begin
    if (strobe.useBin) begin
      candN = binWord[N_W+A_W-1:A_W];
      candA = binWord[A_W-1:0];
    end else begin
      candN = cfgN;
      candA = cfgA;
    end
  end

  // Shadow registers: written at any time, read only at a boundary
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shN <= RST_N;
      shA <= RST_A;
    end else if (strobe.takeNew) begin
      shN <= candN;
      shA <= candA;
    end
  end

  // Main and swallow down-counters
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nCnt <= RST_N;
      aCnt <= RST_A;
    end else if (strobe.reload) begin
      nCnt <= shN;
      aCnt <= shA;
    end else begin
      nCnt <= nCnt - N_W'(1);
      if (strobe.stepA) aCnt <= aCnt - A_W'(1);
    end
  end
endmodule

// File: rtl/swc_control.sv
module swc_control #(
  parameter int P   = 8,
  parameter int N_W = 8,
  parameter int A_W = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrite,
  input  logic                 binWrite,
  input  logic [N_W-1:0]       candN,
  input  logic [A_W-1:0]       candA,
  input  logic [N_W-1:0]       nCnt,
  input  logic [A_W-1:0]       aCnt,
  output swc_pkg::swcStrobe_t  strobe,
  output logic                 modCtl,
  output logic                 refPulse,
  output logic                 cfgErr
);
  localparam bit BIN_OK = (P == 8) || (P == 16) || (P == 32) || (P == 64);
  localparam logic [A_W-1:0] A_TOP = A_W'(P - 1);

  logic binEn;
  logic anyWr;
  logic badCfg;

  // The binary split exists only for power-of-two P in the supported set
  generate
    if (BIN_OK) begin : gBin
      assign binEn = binWrite;
    end else begin : gNoBin
      logic unusedBin;
      assign unusedBin = binWrite;
      assign binEn = 1'b0;
    end
  endgenerate

  assign anyWr  = cfgWrite | binEn;
  assign badCfg = (candN == '0) || (N_W'(candA) > candN) || (candA > A_TOP);

  // Terminal decodes
  assign refPulse = (nCnt == N_W'(1));
  assign modCtl   = (aCnt == '0);

  always_comb begin
    strobe.reload  = refPulse;
    strobe.stepA   = !refPulse && (aCnt != '0);
    strobe.useBin  = !cfgWrite && binEn;
    strobe.takeNew = anyWr && !badCfg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgErr <= 1'b0;
    else       cfgErr <= anyWr && badCfg;
  end
endmodule

// File: rtl/swallow_ctrl_top.sv
module swallow_ctrl_top #(
  parameter int P     = 8,
  parameter int N_W   = 8,
  parameter int DEF_N = 10,
  parameter int DEF_A = 0
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          cfgWrite,
  input  logic [N_W-1:0]                cfgN,
  input  logic [$clog2(P)-1:0]          cfgA,
  input  logic                          binWrite,
  input  logic [N_W+$clog2(P)-1:0]      binWord,
  output logic                          modCtl,
  output logic                          refPulse,
  output logic                          cfgErr
);
  localparam int A_W = $clog2(P);

  generate
    if (P < 3 || P > 128) begin : gBadP
      $error("prescaler modulus P out of range 3..128");
    end
    if (A_W > N_W || DEF_N < 1 || DEF_A > DEF_N || DEF_A > P - 1) begin : gBadDef
      $error("inconsistent width or reset defaults");
    end
  endgenerate

  swc_pkg::swcStrobe_t strobe;
  logic [N_W-1:0] candN;
  logic [A_W-1:0] candA;
  logic [N_W-1:0] nCnt;
  logic [A_W-1:0] aCnt;
  logic [N_W-1:0] shN;
  logic [A_W-1:0] shA;

  swc_control #(.P(P), .N_W(N_W), .A_W(A_W)) uCtl (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .binWrite(binWrite),
    .candN(candN), .candA(candA), .nCnt(nCnt), .aCnt(aCnt),
    .strobe(strobe), .modCtl(modCtl), .refPulse(refPulse), .cfgErr(cfgErr)
  );

  swc_datapath #(.N_W(N_W), .A_W(A_W), .DEF_N(DEF_N), .DEF_A(DEF_A)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgN(cfgN), .cfgA(cfgA),
    .binWord(binWord), .candN(candN), .candA(candA), .nCnt(nCnt),
    .aCnt(aCnt), .shN(shN), .shA(shA)
  );
endmodule

// File: rtl/swc_checker.sv
module swc_checker #(
  parameter int N_W = 8,
  parameter int A_W = 3
) (
  input logic           clk,
  input logic           rstN,
  input logic           modCtl,
  input logic           refPulse,
  input logic           cfgErr,
  input logic [N_W-1:0] nCnt,
  input logic [A_W-1:0] aCnt,
  input logic [N_W-1:0] shN,
  input logic [A_W-1:0] shA
);
  // R2: once divide-by-P is selected it holds to the end of the cycle
  a_r2_mc_holds_high: assert property (@(posedge clk) disable iff (!rstN)
    (modCtl && !refPulse) |=> modCtl);

  // R2: the swallow count never outruns the main count
  a_r2_swallow_within: assert property (@(posedge clk) disable iff (!rstN)
    N_W'(aCnt) <= nCnt);

  // R3: outside the last period the main count steps down by one
  a_r3_main_steps: assert property (@(posedge clk) disable iff (!rstN)
    !refPulse |=> nCnt == $past(nCnt) - N_W'(1));

  // R6: the boundary loads the shadow values held before that edge
  a_r6_reload_shadow: assert property (@(posedge clk) disable iff (!rstN)
    refPulse |=> (nCnt == $past(shN)) && (aCnt == $past(shA)));

  // R5: a refused write leaves the shadow registers untouched
  a_r5_refused_keeps: assert property (@(posedge clk) disable iff (!rstN)
    cfgErr |-> (shN == $past(shN)) && (shA == $past(shA)));

  // R5: stored settings never have A above N or N at zero
  a_r5_shadow_legal: assert property (@(posedge clk) disable iff (!rstN)
    (shN != '0) && (N_W'(shA) <= shN));
endmodule

bind swallow_ctrl_top swc_checker #(.N_W(N_W), .A_W(A_W)) uChk (.*);

// File: tb/sim_swallow_ctrl_top.sv
module sim_swallow_ctrl_top;
  localparam int PERIOD = 10;
  localparam int P      = 8;
  localparam int N_W    = 8;
  localparam int A_W    = 3;
  localparam int DEF_N  = 10;
  localparam int DEF_A  = 0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrite = 1'b0;
  logic [N_W-1:0] cfgN = '0;
  logic [A_W-1:0] cfgA = '0;
  logic binWrite = 1'b0;
  logic [N_W+A_W-1:0] binWord = '0;
  logic modCtl, refPulse, cfgErr;

  swallow_ctrl_top #(.P(P), .N_W(N_W), .DEF_N(DEF_N), .DEF_A(DEF_A)) u0 (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgN(cfgN), .cfgA(cfgA),
    .binWrite(binWrite), .binWord(binWord), .modCtl(modCtl),
    .refPulse(refPulse), .cfgErr(cfgErr)
  );

  always #(PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string phase = "R4";

  // Behavioural reference model
  int mN, mA, sN, sA, curN, curA, wN, wA;
  bit mErr, wr, bad;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mN = DEF_N; mA = DEF_A; sN = DEF_N; sA = DEF_A;
      curN = DEF_N; curA = DEF_A; mErr = 0;
    end else begin
      if (mN == 1) begin
        mN = sN; mA = sA; curN = sN; curA = sA;
      end else begin
        mN = mN - 1;
        if (mA > 0) mA = mA - 1;
      end
      wr = 0; wN = 0; wA = 0;
      if (cfgWrite) begin
        wr = 1; wN = int'(cfgN); wA = int'(cfgA);
      end else if (binWrite) begin
        wr = 1; wN = int'(binWord) / P; wA = int'(binWord) % P;
      end
      bad = (wN == 0) || (wA > wN) || (wA > P - 1);
      mErr = wr && bad;
      if (wr && !bad) begin sN = wN; sA = wA; end
    end
  end

  task automatic chk(input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", phase, what, act, exp);
    end
  endtask

  // Compare on every falling edge; ratio summed per cycle (R1)
  int acc = 0;
  bit skipFirst = 1;
  always @(negedge clk) begin
    if (!rstN) begin
      chk("R4 reset refPulse", int'(refPulse), 0);
      chk("R4 reset modCtl", int'(modCtl), (DEF_A == 0) ? 1 : 0);
      chk("R4 reset cfgErr", int'(cfgErr), 0);
      acc = 0; skipFirst = 1;
    end else begin
      chk("R2 modCtl", int'(modCtl), (mA == 0) ? 1 : 0);
      chk("R3 refPulse", int'(refPulse), (mN == 1) ? 1 : 0);
      chk("R5 cfgErr", int'(cfgErr), int'(mErr));
      acc += modCtl ? P : P + 1;
      if (refPulse) begin
        if (!skipFirst) chk("R1 total ratio", acc, curN * P + curA);
        skipFirst = 0;
        acc = 0;
      end
    end
  end

  task automatic run(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wrCfg(input int n, input int a);
    @(negedge clk);
    cfgWrite = 1'b1; cfgN = N_W'(n); cfgA = A_W'(a);
    @(negedge clk);
    cfgWrite = 1'b0;
  endtask

  task automatic wrBin(input int word);
    @(negedge clk);
    binWrite = 1'b1; binWord = (N_W+A_W)'(word);
    @(negedge clk);
    binWrite = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(PERIOD * 50000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    phase = "R4";
    run(3);
    #1 rstN = 1'b1;
    run(25);

    phase = "R2";
    wrCfg(5, 3);  run(20);
    wrCfg(6, 0);  run(20);
    wrCfg(4, 4);  run(15);

    phase = "R3";
    wrCfg(1, 0);  run(6);
    wrCfg(2, 1);  run(8);

    phase = "R5";
    wrCfg(3, 5);  run(4);
    wrCfg(0, 0);  run(8);

    // R7: word 43 = N 5, A 3 (low 3 bits); word 13 = N 1, A 5 is refused
    phase = "R7";
    wrBin(43);    run(20);
    wrBin(13);    run(20);

    // R8: both strobes together, field write wins
    phase = "R8";
    @(negedge clk);
    cfgWrite = 1'b1; cfgN = 8'd7; cfgA = 3'd2;
    binWrite = 1'b1; binWord = 11'd43;
    @(negedge clk);
    cfgWrite = 1'b0; binWrite = 1'b0;
    run(25);

    // R6: write sampled on the boundary edge, then one mid-cycle
    phase = "R6";
    do @(negedge clk); while (!refPulse);
    cfgWrite = 1'b1; cfgN = 8'd9; cfgA = 3'd2;
    @(negedge clk);
    cfgWrite = 1'b0;
    run(12);
    wrCfg(3, 1);  run(20);

    // R1: consecutive totals, A swept through 0..P-1 then N stepped
    phase = "R1";
    for (int a = 0; a < P; a++) begin
      wrCfg(9, a); run(22);
    end
    wrCfg(10, 0); run(25);
    for (int w = 70; w < 74; w++) begin
      wrBin(w); run(22);
    end

    finishRun();
  end
endmodule